// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a small 32-bit processor that finishes one instruction in every clock cycle. It supports eight instructions: register add, add-immediate, word load, word store, branch-if-equal, absolute jump, jump-and-link and jump-through-register. On each cycle the program counter selects a word from an instruction array inside the block. A decoder turns the opcode (and, for register-format words, the function code) into a control bundle. That bundle steers the operand multiplexers, the adder/subtractor, the data array, the register file write port and the program-counter source. The register state and the next program counter update together on the rising clock edge.

Both memories are plain word arrays held in the block. The surrounding environment loads the instruction array before it releases reset. The write-back and store activity of the current instruction is visible on trace outputs, which lets an observer follow execution one instruction at a time.

Top module: `sc_core`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, the program counter reads 0 and all 32 registers hold 0.
- R2: Encodings are register format {op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]}, immediate format {op, rs, rt, imm[15:0]} and jump format {op, target[25:0]}. The instruction fetched is word pc[.. :2] of the instruction array. An instruction that does not change the flow of control advances the PC by 4, and the PC always has its low two bits at zero.
- R3: op 0x00 with funct 0x20 writes rs+rt into register rd.
- R4: op 0x08 writes rs plus the sign-extended imm into register rt.
- R5: op 0x2B writes the rt value into the data word at byte address rs+sext(imm), and it writes no register.
- R6: op 0x23 writes the data word at byte address rs+sext(imm) into register rt.
- R7: op 0x04 compares rs with rt by subtraction. If they are equal, the next PC is PC+4+(sext(imm)<<2). Otherwise it is PC+4.
- R8: op 0x02 sets the next PC to {(PC+4)[31:28], target, 2'b00}.
- R9: op 0x03 jumps like R8 and also writes PC+4 into register 31.
- R10: op 0x00 with funct 0x08 sets the next PC to the rs value with bits [1:0] cleared, and it writes no register.
- R11: Register 0 always reads as 0. A write aimed at it is dropped, and the write-enable trace stays low.
- R12: Any other opcode, and any other function code under op 0x00, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| instr_o | output | 32 | Instruction word executing this cycle |
| rf_we_o | output | 1 | A register is written at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | The data array is written at the next edge |
| dm_addr_o | output | 32 | Data byte address (the adder result) |
| dm_wdata_o | output | 32 | Store data (rt value) |

## Verification
The bench uses a negative immediate and checks all 32 result bits. A core that zero-extended the immediate would produce 0x0000FFFD instead of 0xFFFFFFFD. Branches are tested three ways: taken forward, not taken, and taken backward to address 0. A core that based the target on PC instead of PC+4, or that ignored the sign of the offset, would land on the wrong word. The link value of the jump-and-link instruction and the alignment mask of the register jump are checked on the trace outputs. Unsupported opcodes and function codes are followed by reads of the registers they could have corrupted. A decoder that let them fall into the add path would leave a nonzero value there.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_LINK  = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_JREG  = 6'h08;

    typedef enum logic {ALU_ADD, ALU_SUB} alu_op_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {NPC_SEQ, NPC_ABS, NPC_REG} npc_sel_e;

    typedef struct packed {
        logic     branch;
        npc_sel_e npc_sel;
        logic     alub_imm;
        alu_op_e  alu_op;
        logic     dm_we;
        logic     rf_we;
        dst_sel_e dst_sel;
        wb_sel_e  wb_sel;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{branch: 1'b0, npc_sel: NPC_SEQ, alub_imm: 1'b0,
                 alu_op: ALU_ADD, dm_we: 1'b0, rf_we: 1'b0,
                 dst_sel: DST_RT, wb_sel: WB_ALU};
        case (opcode)
            OP_RTYPE: begin
                if (funct == FN_ADD) begin
                    ctrl.rf_we   = 1'b1;
                    ctrl.dst_sel = DST_RD;
                end else if (funct == FN_JREG) begin
                    ctrl.npc_sel = NPC_REG;
                end
            end
            OP_ADDI: begin
                ctrl.rf_we    = 1'b1;
                ctrl.alub_imm = 1'b1;
            end
            OP_LOAD: begin
                ctrl.rf_we    = 1'b1;
                ctrl.alub_imm = 1'b1;
                ctrl.wb_sel   = WB_MEM;
            end
            OP_STORE: begin
                ctrl.alub_imm = 1'b1;
                ctrl.dm_we    = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.npc_sel = NPC_ABS;
            end
            OP_LINK: begin
                ctrl.npc_sel = NPC_ABS;
                ctrl.rf_we   = 1'b1;
                ctrl.dst_sel = DST_LINK;
                ctrl.wb_sel  = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y    = (op == ALU_SUB) ? (a - b) : (a + b);
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata
);
    logic [W-1:0] regs_q [NREGS];
    logic [W-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && waddr != '0) begin
            regs_d[waddr] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
    end
endmodule

// File: rtl/sc_imem.sv
module sc_imem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic [W-1:0] addr,
    output logic [W-1:0] rdata
);
    logic [W-1:0] mem [WORDS];

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0;
        end
    end

    assign rdata = mem[addr[IW+1:2]];
endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0] mem [WORDS];
    logic [IW-1:0] idx;

    assign idx   = addr[IW+1:2];
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);
    localparam logic [REG_AW-1:0] LINK_REG = '1;

    core_state_t state_q, state_d;
    ctrl_t       ctrl;

    logic [XLEN-1:0] instr, pc_plus4, imm_sx, br_target, abs_target, reg_target;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rdata;
    logic            alu_zero;
    logic [REG_AW-1:0] dst;
    logic [XLEN-1:0] wb_val;
    logic [1:0][REG_AW-1:0] rd_addr;
    logic [1:0][XLEN-1:0]   rd_data;

    sc_imem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
        .addr (state_q.pc),
        .rdata(instr)
    );

    sc_decoder u_dec (
        .opcode(instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    assign rd_addr[0] = instr[25:21];
    assign rd_addr[1] = instr[20:16];
    assign rs_val     = rd_data[0];
    assign rt_val     = rd_data[1];

    sc_regfile #(.W(XLEN), .NREGS(32), .NRD(2)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .raddr(rd_addr),
        .rdata(rd_data),
        .we   (rf_we_o),
        .waddr(dst),
        .wdata(wb_val)
    );

    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b  = ctrl.alub_imm ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a   (rs_val),
        .b   (alu_b),
        .op  (ctrl.alu_op),
        .y   (alu_y),
        .zero(alu_zero)
    );

    sc_dmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk  (clk),
        .we   (ctrl.dm_we),
        .addr (alu_y),
        .wdata(rt_val),
        .rdata(mem_rdata)
    );

    always_comb begin
        pc_plus4   = state_q.pc + 32'd4;
        br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
        abs_target = {pc_plus4[31:28], instr[25:0], 2'b00};
        reg_target = {rs_val[31:2], 2'b00};

        case (ctrl.dst_sel)
            DST_RD:   dst = instr[15:11];
            DST_LINK: dst = LINK_REG;
            default:  dst = instr[20:16];
        endcase

        case (ctrl.wb_sel)
            WB_MEM:  wb_val = mem_rdata;
            WB_LINK: wb_val = pc_plus4;
            default: wb_val = alu_y;
        endcase

        state_d = state_q;
        case (ctrl.npc_sel)
            NPC_ABS: state_d.pc = abs_target;
            NPC_REG: state_d.pc = reg_target;
            default: state_d.pc = (ctrl.branch && alu_zero) ? br_target : pc_plus4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pc: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign instr_o    = instr;
    assign rf_we_o    = ctrl.rf_we && (dst != '0);
    assign rf_waddr_o = dst;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = ctrl.dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        dm_we
);
    logic [5:0]  op;
    logic [31:0] seq_pc;
    logic [31:0] jmp_pc;
    logic        plain_op;
    logic        known_op;

    assign op       = instr[31:26];
    assign seq_pc   = pc + 32'd4;
    assign jmp_pc   = {seq_pc[31:28], instr[25:0], 2'b00};
    assign plain_op = (op == 6'h08) || (op == 6'h23) || (op == 6'h2B);
    assign known_op = plain_op || (op == 6'h00) || (op == 6'h02) ||
                      (op == 6'h03) || (op == 6'h04);

    // R1
    reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc == 32'd0);

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plain_op |=> pc == $past(seq_pc));

    // R8
    abs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h02) |=> pc == $past(jmp_pc));

    // R5
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we);

    // R11
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr != 5'd0);

    // R12
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc_o),
    .instr   (instr_o),
    .rf_we   (rf_we_o),
    .rf_waddr(rf_waddr_o),
    .dm_we   (dm_we_o)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;
    int checks = 0;
    int errors = 0;

    sc_core uut (
        .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .instr_o(instr_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
        return {op, tgt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) uut.u_imem.mem[i] = 32'h0;
    endtask

    task automatic start();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        clear_prog();
        uut.u_imem.mem[0] = enc_r(5'd7, 5'd8, 5'd9, 6'h20);
        @(negedge clk);
        check("R1 pc in reset", pc_o, 32'h0);
        start();
        check("R1 registers cleared", rf_wdata_o, 32'h0);
        check("R1 first fetch", instr_o, enc_r(5'd7, 5'd8, 5'd9, 6'h20));
    endtask

    task automatic t_alu();
        clear_prog();
        uut.u_imem.mem[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
        uut.u_imem.mem[1] = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
        uut.u_imem.mem[2] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        uut.u_imem.mem[3] = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
        uut.u_imem.mem[4] = enc_r(5'd0, 5'd0, 5'd4, 6'h20);
        start();
        check("R4 addi we", {31'd0, rf_we_o}, 32'd1);
        check("R4 addi dest", {27'd0, rf_waddr_o}, 32'd1);
        check("R4 addi value", rf_wdata_o, 32'd5);
        step();
        check("R2 pc plus 4", pc_o, 32'd4);
        check("R4 negative imm", rf_wdata_o, 32'hFFFFFFFD);
        step();
        check("R3 add dest", {27'd0, rf_waddr_o}, 32'd3);
        check("R3 add value", rf_wdata_o, 32'd2);
        step();
        check("R11 r0 write dropped", {31'd0, rf_we_o}, 32'd0);
        step();
        check("R11 r0 reads zero", rf_wdata_o, 32'd0);
        check("R11 add to r4 we", {31'd0, rf_we_o}, 32'd1);
    endtask

    task automatic t_mem();
        clear_prog();
        uut.u_imem.mem[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd16);
        uut.u_imem.mem[1] = enc_i(6'h08, 5'd0, 5'd2, 16'h1234);
        uut.u_imem.mem[2] = enc_i(6'h2B, 5'd1, 5'd2, 16'd4);
        uut.u_imem.mem[3] = enc_i(6'h08, 5'd0, 5'd6, 16'd24);
        uut.u_imem.mem[4] = enc_i(6'h23, 5'd6, 5'd3, 16'hFFFC);
        start();
        step();
        step();
        check("R5 store we", {31'd0, dm_we_o}, 32'd1);
        check("R5 store addr", dm_addr_o, 32'd20);
        check("R5 store data", dm_wdata_o, 32'h1234);
        check("R5 no reg write", {31'd0, rf_we_o}, 32'd0);
        step();
        step();
        check("R6 load addr", dm_addr_o, 32'd20);
        check("R6 load dest", {27'd0, rf_waddr_o}, 32'd3);
        check("R6 load value", rf_wdata_o, 32'h1234);
    endtask

    task automatic t_branch();
        clear_prog();
        uut.u_imem.mem[0] = enc_i(6'h08, 5'd0, 5'd1, 16'd7);
        uut.u_imem.mem[1] = enc_i(6'h08, 5'd0, 5'd2, 16'd7);
        uut.u_imem.mem[2] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
        uut.u_imem.mem[5] = enc_i(6'h04, 5'd1, 5'd0, 16'd5);
        uut.u_imem.mem[6] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFF9);
        start();
        step();
        step();
        check("R7 beq no write", {31'd0, rf_we_o}, 32'd0);
        step();
        check("R7 taken forward", pc_o, 32'd20);
        step();
        check("R7 not taken", pc_o, 32'd24);
        step();
        check("R7 taken backward", pc_o, 32'd0);
    endtask

    task automatic t_jump();
        clear_prog();
        uut.u_imem.mem[0]  = enc_j(6'h03, 26'd5);
        uut.u_imem.mem[1]  = enc_i(6'h08, 5'd0, 5'd7, 16'd9);
        uut.u_imem.mem[5]  = enc_j(6'h02, 26'd10);
        uut.u_imem.mem[10] = enc_r(5'd31, 5'd0, 5'd0, 6'h08);
        start();
        check("R9 link dest", {27'd0, rf_waddr_o}, 32'd31);
        check("R9 link value", rf_wdata_o, 32'd4);
        step();
        check("R9 jump target", pc_o, 32'd20);
        step();
        check("R8 jump target", pc_o, 32'd40);
        check("R10 jr no write", {31'd0, rf_we_o}, 32'd0);
        step();
        check("R10 jr target", pc_o, 32'd4);
        check("R10 resume", rf_wdata_o, 32'd9);
    endtask

    task automatic t_unknown();
        clear_prog();
        uut.u_imem.mem[0] = enc_i(6'h08, 5'd0, 5'd5, 16'd9);
        uut.u_imem.mem[1] = enc_i(6'h3F, 5'd5, 5'd1, 16'h0055);
        uut.u_imem.mem[2] = enc_r(5'd5, 5'd5, 5'd2, 6'h22);
        uut.u_imem.mem[3] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        uut.u_imem.mem[4] = enc_i(6'h08, 5'd0, 5'd1, 16'd14);
        uut.u_imem.mem[5] = enc_r(5'd1, 5'd0, 5'd0, 6'h08);
        start();
        step();
        check("R12 bad op no reg write", {31'd0, rf_we_o}, 32'd0);
        check("R12 bad op no store", {31'd0, dm_we_o}, 32'd0);
        step();
        check("R12 bad op advances", pc_o, 32'd8);
        check("R12 bad funct no write", {31'd0, rf_we_o}, 32'd0);
        step();
        check("R12 registers untouched", rf_wdata_o, 32'd0);
        step();
        step();
        step();
        check("R2 jr target aligned", pc_o, 32'd12);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset();
        t_alu();
        t_mem();
        t_branch();
        t_jump();
        t_unknown();
        summary();
    end
endmodule